// File: doc/BRIEF.md
# Handshaked Add/Subtract Dataflow Node

This block is one 32-bit arithmetic node of a dataflow fabric. It takes a left operand and a right operand on two input edges, adds or subtracts them, and offers the result on two output edges. Each edge has three parts: a data bus, a request flag that the sender raises while its data is valid, and an acknowledge flag that the receiver raises in the cycle it takes that data. The node has no central sequencer. It fires when its operands are present and its result register can take a new value. In the same cycle it acknowledges its producers, so back-pressure from the consumers reaches the producers through combinational logic.

Two static configuration inputs set the operation: add or subtract, and whether the right operand comes from the input edge or from a constant input. The result register feeds both consumers. For each consumer the node keeps a flag that records whether that consumer has already taken the current value. The register is released only when every consumer has taken it, and it can be reloaded in the same cycle it is released. This lets an unstalled pipeline run at one result per clock.

Top module: `dfg_addsub_node`

## Requirements
- R1: While `rst_ni` is low, both operand acknowledges are low whatever the input requests are. After reset is released, both output requests are low until the first operand pair has been accepted.
- R2: With `cfg_sub_i`=0 and `cfg_imm_i`=0, the result is the sum of the left and right operand data modulo 2^32.
- R3: With `cfg_sub_i`=1 and `cfg_imm_i`=0, the result is the left operand minus the right operand data modulo 2^32.
- R4: With `cfg_imm_i`=1, `cfg_const_i` takes the place of the right operand in the add or subtract. The right-edge request and data are ignored, and `rgt_ack_o` stays low.
- R5: The node accepts operands only when the left request is high, the right request is also high (unless R4 applies), and the result register is free or being released in that cycle. The accepted edges are acknowledged together, in the cycle of acceptance.
- R6: The clock edge that accepts an operand pair loads the result. In the next cycle both output requests are high and both output data buses carry the result.
- R7: When both consumers acknowledge every cycle and operands are always present, the node accepts a new operand pair every cycle.
- R8: While any consumer has not acknowledged the current result, the output data stays unchanged, that consumer's request stays high, and no new operands are accepted unless the last pending consumer is acknowledging in that cycle.
- R9: A consumer that has acknowledged sees its request low until the next result is loaded. The register is released only in the cycle the last pending consumer acknowledges, and in that same cycle the node may accept new operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_sub_i | input | 1 | 1 selects subtract, 0 selects add |
| cfg_imm_i | input | 1 | 1 uses the constant as the right operand |
| cfg_const_i | input | 32 | Constant used as the right operand in immediate mode |
| lft_data_i | input | 32 | Left operand data |
| lft_req_i | input | 1 | Left operand valid |
| lft_ack_o | output | 1 | Left operand taken |
| rgt_data_i | input | 32 | Right operand data |
| rgt_req_i | input | 1 | Right operand valid |
| rgt_ack_o | output | 1 | Right operand taken |
| out_data_o | output | 2x32 | Result data, one bus per consumer |
| out_req_o | output | 2 | Result valid, one per consumer |
| out_ack_i | input | 2 | Result taken, one per consumer |

## Verification
A wrong sent flag shows at the ports in the cycle after a partial acknowledge. Either a request that was already served comes back, or a request disappears before that consumer took the value. A stuck valid bit shows as operand acknowledges that never return, or as a result overwritten while a consumer is still pending, in the first stalled cycle. A wrong operand select or operation shows on the output data one cycle after acceptance. The operand sweep across all four modes uses wrap-around values so that these errors produce visible differences.

// File: rtl/dfg_pkg.sv
package dfg_pkg;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned NUM_OUT = 2;

  typedef struct packed {
    logic sub;
    logic imm;
  } op_cfg_t;
endpackage

// File: rtl/dfg_join.sv
module dfg_join (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic imm_i,
  input  logic lft_req_i,
  input  logic rgt_req_i,
  input  logic slot_free_i,
  output logic fire_o,
  output logic lft_ack_o,
  output logic rgt_ack_o
);
  logic operands_ok;

  assign operands_ok = lft_req_i & (imm_i | rgt_req_i);
  // gating with reset keeps acks low while in reset
  assign fire_o      = rst_ni & operands_ok & slot_free_i;
  assign lft_ack_o   = fire_o;
  assign rgt_ack_o   = fire_o & ~imm_i;

  AST_ACK_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lft_ack_o |-> lft_req_i);  // R5
  AST_ACK_PAIRED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!imm_i && lft_ack_o) |-> (rgt_ack_o && rgt_req_i));  // R5
  AST_IMM_NO_RGT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    imm_i |-> !rgt_ack_o);  // R4
endmodule

// File: rtl/dfg_addsub_alu.sv
module dfg_addsub_alu #(
  parameter int unsigned W = 32
) (
  input  dfg_pkg::op_cfg_t cfg_i,
  input  logic [W-1:0]     lft_i,
  input  logic [W-1:0]     rgt_i,
  input  logic [W-1:0]     const_i,
  output logic [W-1:0]     res_o
);
  logic [W-1:0] opb;

  assign opb   = cfg_i.imm ? const_i : rgt_i;
  assign res_o = cfg_i.sub ? (lft_i - opb) : (lft_i + opb);
endmodule

// File: rtl/dfg_fork.sv
module dfg_fork #(
  parameter int unsigned N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [N-1:0] ack_i,
  output logic [N-1:0] req_o,
  output logic         free_o
);
  logic         valid_q;
  logic [N-1:0] sent_q;
  logic [N-1:0] done;
  logic         drain;

  for (genvar k = 0; k < N; k++) begin : g_lane
    assign req_o[k] = valid_q & ~sent_q[k];
    assign done[k]  = sent_q[k] | ack_i[k];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                 sent_q[k] <= 1'b0;
      else if (load_i || drain)    sent_q[k] <= 1'b0;
      else if (req_o[k] && ack_i[k]) sent_q[k] <= 1'b1;
    end

    AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_o[k] && !ack_i[k]) |=> req_o[k]);  // R8
    AST_NO_REPEAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_o[k] && ack_i[k] && !load_i) |=> !req_o[k]);  // R9
  end

  assign drain  = valid_q & (&done);
  assign free_o = ~valid_q | drain;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     valid_q <= 1'b0;
    else if (load_i) valid_q <= 1'b1;
    else if (drain)  valid_q <= 1'b0;
  end

  AST_LOAD_ALL_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (&req_o));  // R6
endmodule

// File: rtl/dfg_addsub_node.sv
module dfg_addsub_node #(
  parameter int unsigned W = dfg_pkg::DATA_W,
  parameter int unsigned N = dfg_pkg::NUM_OUT
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cfg_sub_i,
  input  logic                cfg_imm_i,
  input  logic [W-1:0]        cfg_const_i,
  input  logic [W-1:0]        lft_data_i,
  input  logic                lft_req_i,
  output logic                lft_ack_o,
  input  logic [W-1:0]        rgt_data_i,
  input  logic                rgt_req_i,
  output logic                rgt_ack_o,
  output logic [N-1:0][W-1:0] out_data_o,
  output logic [N-1:0]        out_req_o,
  input  logic [N-1:0]        out_ack_i
);
  dfg_pkg::op_cfg_t cfg;
  logic             fire;
  logic             slot_free;
  logic [W-1:0]     alu_res;
  logic [W-1:0]     data_q;

  assign cfg.sub = cfg_sub_i;
  assign cfg.imm = cfg_imm_i;

  dfg_join u_join (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .imm_i      (cfg_imm_i),
    .lft_req_i  (lft_req_i),
    .rgt_req_i  (rgt_req_i),
    .slot_free_i(slot_free),
    .fire_o     (fire),
    .lft_ack_o  (lft_ack_o),
    .rgt_ack_o  (rgt_ack_o)
  );

  dfg_addsub_alu #(.W(W)) u_alu (
    .cfg_i  (cfg),
    .lft_i  (lft_data_i),
    .rgt_i  (rgt_data_i),
    .const_i(cfg_const_i),
    .res_o  (alu_res)
  );

  dfg_fork #(.N(N)) u_fork (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(fire),
    .ack_i (out_ack_i),
    .req_o (out_req_o),
    .free_o(slot_free)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   data_q <= '0;
    else if (fire) data_q <= alu_res;
  end

  for (genvar k = 0; k < N; k++) begin : g_out
    assign out_data_o[k] = data_q;

    AST_DATA_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (out_req_o[k] && !out_ack_i[k]) |=> $stable(out_data_o[k]));  // R8
  end

  AST_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |=> (out_data_o[0] == $past(alu_res)));  // R6
  AST_NO_OVERWRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && (|out_req_o)) |-> ((out_req_o & ~out_ack_i) == '0));  // R9
endmodule

// File: tb/sim_dfg_addsub_node.sv
module sim_dfg_addsub_node;
  localparam int CLK_PERIOD = 10;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             cfg_sub = 1'b0, cfg_imm = 1'b0;
  logic [31:0]      cfg_const = '0, lft_data = '0, rgt_data = '0;
  logic             lft_req = 1'b0, rgt_req = 1'b0;
  logic             lft_ack, rgt_ack;
  logic [1:0][31:0] out_data;
  logic [1:0]       out_req;
  logic [1:0]       out_ack = 2'b00;
  int               n_cmp = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dfg_addsub_node u0 (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_sub_i(cfg_sub), .cfg_imm_i(cfg_imm),
    .cfg_const_i(cfg_const), .lft_data_i(lft_data), .lft_req_i(lft_req),
    .lft_ack_o(lft_ack), .rgt_data_i(rgt_data), .rgt_req_i(rgt_req),
    .rgt_ack_o(rgt_ack), .out_data_o(out_data), .out_req_o(out_req),
    .out_ack_i(out_ack)
  );

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic step;
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [31:0] pick(input int i);
    case (i)
      0: return 32'h0000_0000;
      1: return 32'h0000_0001;
      2: return 32'h7FFF_FFFF;
      3: return 32'h8000_0000;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog R1..: run did not complete");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] prev;
    // R1: acks held low in reset despite requests
    lft_req = 1'b1; rgt_req = 1'b1;
    @(negedge clk); #1;
    chk("R1 lft_ack in reset", {31'b0, lft_ack}, 32'd0);
    chk("R1 rgt_ack in reset", {31'b0, rgt_ack}, 32'd0);
    lft_req = 1'b0; rgt_req = 1'b0;
    step();
    rst_ni = 1'b1;
    step(); #1;
    chk("R1 out_req after reset", {30'b0, out_req}, 32'd0);

    // R2 R3 R4: sweep of modes and wrap-around operands, staggered acks
    for (int m = 0; m < 4; m++) begin
      for (int i = 0; i < 5; i++) begin
        for (int j = 0; j < 5; j++) begin
          logic [31:0] a, b, exp;
          string tag;
          a = pick(i); b = pick(j);
          cfg_sub = m[0]; cfg_imm = m[1];
          lft_data = a;
          if (cfg_imm) begin cfg_const = b; rgt_data = ~b; end
          else begin cfg_const = ~b; rgt_data = b; end
          exp = cfg_sub ? a - b : a + b;
          tag = cfg_imm ? "R4" : (cfg_sub ? "R3" : "R2");
          lft_req = 1'b1; rgt_req = 1'b1; out_ack = 2'b00;
          #1;
          chk("R5 lft_ack on accept", {31'b0, lft_ack}, 32'd1);
          chk("R4 rgt_ack vs mode", {31'b0, rgt_ack}, {31'b0, ~cfg_imm});
          step();
          lft_req = 1'b0; rgt_req = 1'b0;
          #1;
          chk("R6 both reqs", {30'b0, out_req}, 32'd3);
          chk({tag, " result lane0"}, out_data[0], exp);
          chk({tag, " result lane1"}, out_data[1], exp);
          out_ack = 2'b01;
          step();
          out_ack = 2'b00;
          #1;
          chk("R9 lane0 served, lane1 pending", {30'b0, out_req}, 32'd2);
          chk("R8 data held for lane1", out_data[1], exp);
          out_ack = 2'b10;
          step();
          out_ack = 2'b00;
          #1;
          chk("R9 all served", {30'b0, out_req}, 32'd0);
        end
      end
    end

    // R5: join waits for both operands
    cfg_sub = 1'b0; cfg_imm = 1'b0;
    lft_data = 32'd40; rgt_data = 32'd2;
    lft_req = 1'b1; rgt_req = 1'b0;
    #1;
    chk("R5 no ack with one operand", {30'b0, rgt_ack, lft_ack}, 32'd0);
    step(); #1;
    chk("R5 no fire with one operand", {30'b0, out_req}, 32'd0);
    chk("R5 still no ack", {30'b0, rgt_ack, lft_ack}, 32'd0);
    rgt_req = 1'b1;
    #1;
    chk("R5 joint ack", {30'b0, rgt_ack, lft_ack}, 32'd3);
    step();
    lft_req = 1'b0; rgt_req = 1'b0;
    #1;
    chk("R2 join result", out_data[0], 32'd42);
    out_ack = 2'b11;
    step();
    out_ack = 2'b00;

    // R4: immediate mode fires without right request
    cfg_imm = 1'b1; cfg_sub = 1'b1; cfg_const = 32'd5;
    lft_data = 32'd3; lft_req = 1'b1; rgt_req = 1'b0;
    #1;
    chk("R4 fires without right req", {30'b0, rgt_ack, lft_ack}, 32'd1);
    step();
    lft_req = 1'b0;
    #1;
    chk("R4 imm subtract", out_data[1], 32'hFFFF_FFFE);
    out_ack = 2'b11;
    step();
    out_ack = 2'b00;

    // R7: full throughput with continuous acks
    cfg_imm = 1'b0; cfg_sub = 1'b0; out_ack = 2'b11;
    prev = '0;
    for (int k = 0; k < 8; k++) begin
      lft_data = k * 5 + 3; rgt_data = k + 100;
      lft_req = 1'b1; rgt_req = 1'b1;
      #1;
      chk("R7 accept every cycle", {31'b0, lft_ack}, 32'd1);
      if (k > 0) begin
        chk("R7 reqs every cycle", {30'b0, out_req}, 32'd3);
        chk("R7 streamed result", out_data[0], prev);
      end
      prev = lft_data + rgt_data;
      step();
    end
    lft_req = 1'b0; rgt_req = 1'b0;
    #1;
    chk("R7 last result", out_data[1], prev);
    step(); #1;
    chk("R7 drained", {30'b0, out_req}, 32'd0);
    out_ack = 2'b00;

    // R8 R9: stall, partial ack, drain and accept in one cycle
    cfg_sub = 1'b1;
    lft_data = 32'd10; rgt_data = 32'd3; lft_req = 1'b1; rgt_req = 1'b1;
    step();
    lft_data = 32'd20; rgt_data = 32'd4;
    for (int s = 0; s < 3; s++) begin
      #1;
      chk("R8 no accept while stalled", {31'b0, lft_ack}, 32'd0);
      chk("R8 data stable while stalled", out_data[0], 32'd7);
      step();
    end
    out_ack = 2'b01;
    #1;
    chk("R9 one ack does not free", {31'b0, lft_ack}, 32'd0);
    step();
    out_ack = 2'b10;
    #1;
    chk("R9 accept on final ack", {31'b0, lft_ack}, 32'd1);
    step();
    out_ack = 2'b00; lft_req = 1'b0; rgt_req = 1'b0;
    #1;
    chk("R9 new result reqs", {30'b0, out_req}, 32'd3);
    chk("R3 new result", out_data[0], 32'd16);
    out_ack = 2'b11;
    step();
    out_ack = 2'b00;
    #1;
    chk("R9 final drain", {30'b0, out_req}, 32'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule